// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block collects peripheral interrupt requests (24 with the default parameters) and folds them into one registered request line for a host processor. Software on the host reaches the block through a small byte-wide register port. For each group of eight inputs there is one status register and one enable register. A host interrupt handler reads the status registers to find which sources fired. It controls which sources may reach the host by setting bits in the enable registers.

Most inputs are treated as edge events. After synchronisation, a rising edge on an enabled input latches a pending bit. Reading the status register of that group clears its latched edge bits, so no separate acknowledge register exists. An edge that arrives while its input is disabled is dropped and not remembered. One input, chosen by parameter (input 5 by default), is a level source. Its status bit shows the synchronised live level and is never cleared by a read. The combined output is high when any status bit is set together with its enable bit.

Top module: `cascade_irq_agg`

## Requirements
- R1: After reset every enable register reads 0x00, every status register reads 0x00 and `cascade_o` is low.
- R2: The address is decoded as {group, kind}. `addr[0]`=1 selects the enable register and `addr[0]`=0 selects the status register. `addr[2:1]` selects the group: 0 is inputs 0..7, 1 is inputs 8..15, 2 is inputs 16..23. Enable registers can be written and read back. Address 6 and address 7 read as 0x00.
- R3: A rising edge on an enabled edge input sets status bit n of its group, where n is the input index minus the group base. `rd_data` is registered and is valid in the cycle after `rd_en`.
- R4: A status read returns that group's status and then clears that group's latched edge bits. It leaves the other groups and the enable registers unchanged.
- R5: The status bit of the level input (input 5, group 0 bit 5) follows its synchronised level. The mask does not affect it and a read does not clear it.
- R6: An edge on an input whose enable bit is 0 is not latched. An input that is still held high when it is later enabled is not reported.
- R7: `cascade_o` is registered. It is high one cycle after any status bit and its enable bit are both 1, and low otherwise.
- R8: If an edge is detected in the same cycle that its group's status is read, the read returns the old value and the new edge stays latched.
- R9: A write to a status address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Asynchronous request inputs |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address {group, kind} |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cascade_o | output | 1 | Combined request to host |

## Verification
The bench checks a new edge that reaches the latch in the same cycle its group is read. A design that lets the clear win would silently lose that request. It also holds an input high while it is disabled and then enables it. A design that latched edges without looking at the mask, or that re-evaluated the level at the moment of enabling, would report a request that should be lost. The level input is read twice in a row, which exposes a design that clears it like an edge bit. Reads of one group are followed by reads of another, which catches a clear that spreads across groups.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_MASK   = 1'b1
    } reg_kind_e;

    function automatic reg_kind_e kind_of(input logic lsb);
        return lsb ? REG_MASK : REG_STATUS;
    endfunction

endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] edge_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign edge_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/cirq_bank.sv
module cirq_bank #(
    parameter int W         = 8,
    parameter bit LEVEL_EN  = 1'b0,
    parameter int LEVEL_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] edge_i,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    input  logic         stat_rd,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] cap_o,
    output logic [W-1:0] status_o
);
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] LVL_MASK = LEVEL_EN ? (ONE << LEVEL_BIT) : '0;

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] cap;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] set_vec;

    always_comb begin
        clr_vec = stat_rd ? {W{1'b1}} : '0;
        set_vec = edge_i & st_q.mask & ~LVL_MASK;
        st_d    = st_q;
        if (mask_we) st_d.mask = wdata;
        // set is applied after clear, so a fresh edge survives a read
        st_d.cap = (st_q.cap & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign cap_o    = st_q.cap;
    assign status_o = (st_q.cap & ~LVL_MASK) | (sync_i & LVL_MASK);
endmodule

// File: rtl/cascade_irq_agg.sv
module cascade_irq_agg #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int LEVEL_IDX = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wr_data,
    output logic [BANK_W-1:0]           rd_data,
    output logic                        cascade_o
);
    import cirq_pkg::*;

    localparam int N         = NUM_BANKS * BANK_W;
    localparam int LVL_BANK  = LEVEL_IDX / BANK_W;
    localparam int LVL_BIT   = LEVEL_IDX % BANK_W;

    logic [N-1:0] sync_all;
    logic [N-1:0] edge_all;
    logic [N-1:0] mask_all;
    logic [N-1:0] cap_all;
    logic [N-1:0] status_all;

    reg_kind_e             kind;
    logic [ADDR_W-2:0]     sel;

    assign kind = kind_of(addr[0]);
    assign sel  = addr[ADDR_W-1:1];

    cirq_sync #(.W(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_in),
        .sync_o (sync_all),
        .edge_o (edge_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (int'(sel) == b);

        cirq_bank #(
            .W         (BANK_W),
            .LEVEL_EN  (LVL_BANK == b),
            .LEVEL_BIT ((LVL_BANK == b) ? LVL_BIT : 0)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_all[b*BANK_W +: BANK_W]),
            .edge_i   (edge_all[b*BANK_W +: BANK_W]),
            .mask_we  (wr_en && hit && (kind == REG_MASK)),
            .wdata    (wr_data),
            .stat_rd  (rd_en && hit && (kind == REG_STATUS)),
            .mask_o   (mask_all[b*BANK_W +: BANK_W]),
            .cap_o    (cap_all[b*BANK_W +: BANK_W]),
            .status_o (status_all[b*BANK_W +: BANK_W])
        );
    end

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              casc;
    } out_st_t;

    out_st_t           out_d, out_q;
    logic [BANK_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(sel) == b) begin
                rd_word = (kind == REG_MASK) ? mask_all[b*BANK_W +: BANK_W]
                                             : status_all[b*BANK_W +: BANK_W];
            end
        end
        out_d      = out_q;
        if (rd_en) out_d.rdata = rd_word;
        out_d.casc = |(status_all & mask_all);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data   = out_q.rdata;
    assign cascade_o = out_q.casc;
endmodule

// File: rtl/cascade_irq_agg_chk.sv
module cascade_irq_agg_chk #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_en,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [BANK_W-1:0]           wr_data,
    input logic                        cascade_o,
    input logic [NUM_BANKS*BANK_W-1:0] mask_all,
    input logic [NUM_BANKS*BANK_W-1:0] cap_all,
    input logic [NUM_BANKS*BANK_W-1:0] edge_all
);
    assert_casc_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_o |-> ($past(mask_all) != '0));

    assert_masked_edge_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_all & ~$past(cap_all) & ~$past(mask_all)) == '0));

    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[0]) |=> $stable(mask_all));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !addr[0] && (int'(addr[ADDR_W-1:1]) == b))
            |=> ((cap_all[b*BANK_W +: BANK_W]
                  & ~$past(edge_all[b*BANK_W +: BANK_W])) == '0));

        assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr[0] && (int'(addr[ADDR_W-1:1]) == b))
            |=> (mask_all[b*BANK_W +: BANK_W] == $past(wr_data)));
    end
endmodule

bind cascade_irq_agg cascade_irq_agg_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .cascade_o (cascade_o),
    .mask_all  (mask_all),
    .cap_all   (cap_all),
    .edge_all  (edge_all)
);

// File: tb/cascade_irq_agg_tb.sv
module cascade_irq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_in = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        cascade_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cascade_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cascade_o(cascade_o)
    );

    // {op, addr, data}: op 0 = write, op 1 = read and compare
    localparam logic [11:0] VEC [10] = '{
        {1'b0, 3'd1, 8'hA5}, {1'b0, 3'd3, 8'h3C}, {1'b0, 3'd5, 8'h81},
        {1'b1, 3'd1, 8'hA5}, {1'b1, 3'd3, 8'h3C}, {1'b1, 3'd5, 8'h81},
        {1'b0, 3'd0, 8'hFF}, {1'b1, 3'd1, 8'hA5}, {1'b1, 3'd6, 8'h00},
        {1'b1, 3'd7, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cascade", {7'd0, cascade_o}, 8'h00);
        for (int b = 0; b < 3; b++) begin
            rd(3'(2*b+1), v); chk("R1 mask", v, 8'h00);
            rd(3'(2*b), v);   chk("R1 status", v, 8'h00);
        end

        // R2 / R9 register table
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][11]) begin
                rd(VEC[i][10:8], v);
                chk("R2/R9 table", v, VEC[i][7:0]);
            end else begin
                wr(VEC[i][10:8], VEC[i][7:0]);
            end
        end
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);

        // R3 / R7 / R4: single edge on input 9
        wr(3'd3, 8'hFF);
        @(negedge clk) irq_in[9] = 1'b1;
        settle();
        chk("R7 cascade high", {7'd0, cascade_o}, 8'h01);
        rd(3'd2, v); chk("R3 status bank1", v, 8'h02);
        rd(3'd2, v); chk("R4 cleared", v, 8'h00);
        settle();
        chk("R7 cascade low", {7'd0, cascade_o}, 8'h00);
        irq_in[9] = 1'b0;

        // R4: read of one group leaves the other intact
        wr(3'd5, 8'hFF);
        @(negedge clk) begin irq_in[12] = 1'b1; irq_in[17] = 1'b1; end
        settle();
        rd(3'd3, v); chk("R4 mask read no clear", v, 8'hFF);
        rd(3'd2, v); chk("R4 bank1", v, 8'h10);
        rd(3'd4, v); chk("R4 bank2 kept", v, 8'h02);
        rd(3'd4, v); chk("R4 bank2 cleared", v, 8'h00);
        irq_in = '0;
        wr(3'd3, 8'h00); wr(3'd5, 8'h00);

        // R5 level input
        @(negedge clk) irq_in[5] = 1'b1;
        settle();
        rd(3'd0, v); chk("R5 level masked", v, 8'h20);
        chk("R7 masked level no cascade", {7'd0, cascade_o}, 8'h00);
        wr(3'd1, 8'h20);
        settle();
        chk("R7 level cascade", {7'd0, cascade_o}, 8'h01);
        rd(3'd0, v); chk("R5 level read1", v, 8'h20);
        rd(3'd0, v); chk("R5 level not cleared", v, 8'h20);
        irq_in[5] = 1'b0;
        settle();
        rd(3'd0, v); chk("R5 level low", v, 8'h00);
        chk("R7 level gone", {7'd0, cascade_o}, 8'h00);

        // R6 masked edge lost
        wr(3'd1, 8'h00);
        @(negedge clk) irq_in[1] = 1'b1;
        settle();
        wr(3'd1, 8'h02);
        settle();
        rd(3'd0, v); chk("R6 lost edge", v, 8'h00);
        chk("R6 no cascade", {7'd0, cascade_o}, 8'h00);
        irq_in[1] = 1'b0;
        wr(3'd1, 8'h00);

        // R8 edge coincides with a status read
        wr(3'd5, 8'hFF);
        @(negedge clk) irq_in[20] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'd4;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 old value", rd_data, 8'h00);
        rd(3'd4, v); chk("R8 edge kept", v, 8'h10);
        rd(3'd4, v); chk("R8 then cleared", v, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule